// File: doc/BRIEF.md
# Set-Predicted Logical-Tag Cache Directory

This block is the directory of a first-level cache that is searched directly with a logical address and an address-space identifier (ASID), so no separate first-level translation buffer sits in front of it. A small per-index way predictor names one way for each lookup. The directory reads only the entry in that way and compares its stored logical tag and ASID against the request. There is no compare across all ways. The result is reported as a hit or a miss, together with the way that was probed. On a miss the block raises a request toward the second-level translation and cache pipeline and holds it until that pipeline accepts it.

The directory has 64 index classes and 8 ways. It is stored as one array that is eight times deeper than the number of classes, and the row address is the index followed by the way number. Resolved misses come back as install writes. An install fills one entry and points the predictor of its index at the installed way. Translation purges sweep all 64 indices, one per cycle. A purge either clears every entry or clears only the entries whose stored ASID equals a given value. New lookups are stalled while the sweep runs.

Top module: `ltag_dir`

## Requirements
- R1: After reset every entry is invalid, the predictor of every index points at way 0, `req_ready` is 1, and `purge_busy`, `rsp_valid` and `miss_valid` are 0. A lookup right after reset therefore misses and reports `rsp_set` = 0.
- R2: An install writes entry row {inst_idx, inst_set} as valid with the given tag and ASID, and sets the predictor of `inst_idx` to `inst_set`. A later lookup with the same index, tag and ASID reports a hit with `rsp_set` = `inst_set`.
- R3: A lookup misses when the probed entry's tag differs from the request or its ASID differs from the request, even though the entry is valid.
- R4: A lookup probes only the way the predictor names. An entry that is valid and matching but sits in another way of the same index does not produce a hit.
- R5: A request accepted in the cycle where `req_valid` and `req_ready` are both 1 yields `rsp_valid` in the next cycle and in no other cycle. A new request can be accepted every cycle.
- R6: On a miss, `miss_valid` rises in the response cycle and carries the index, tag and ASID of the lookup. The request and its payload hold until `miss_ready` is 1, and `req_ready` stays 0 while `miss_valid` is 1.
- R7: `purge_start` with `purge_all` = 1 starts a sweep that clears every entry. `purge_busy` stays at 1 for exactly 64 cycles, and `req_ready` is 0 during that time.
- R8: `purge_start` with `purge_all` = 0 clears only the entries whose stored ASID equals `purge_asid`. Entries with any other ASID keep their contents.
- R9: While `purge_busy` is 1, installs are ignored, so neither the entry nor the predictor changes. A further `purge_start` is also ignored and does not lengthen the sweep.
- R10: A purge leaves the predictor untouched. After a purge, a lookup reports the way that was last installed at that index.
- R11: When an install and an accepted lookup fall in the same cycle, the lookup sees the directory and predictor as they were before that install.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| req_idx | input | 6 | Lookup index class |
| req_tag | input | 13 | Lookup logical tag |
| req_asid | input | 8 | Lookup address-space identifier |
| rsp_valid | output | 1 | Result of the lookup accepted in the previous cycle |
| rsp_hit | output | 1 | Probed entry matched |
| rsp_miss | output | 1 | Probed entry did not match |
| rsp_set | output | 3 | Way that was probed |
| miss_valid | output | 1 | Miss request toward the next level |
| miss_ready | input | 1 | Next level accepts the miss request |
| miss_idx | output | 6 | Index of the missing lookup |
| miss_tag | output | 13 | Tag of the missing lookup |
| miss_asid | output | 8 | ASID of the missing lookup |
| inst_valid | input | 1 | Install write |
| inst_idx | input | 6 | Install index |
| inst_set | input | 3 | Install way |
| inst_tag | input | 13 | Install tag |
| inst_asid | input | 8 | Install ASID |
| purge_start | input | 1 | Start a purge sweep |
| purge_all | input | 1 | 1: clear all entries, 0: clear by ASID |
| purge_asid | input | 8 | ASID to clear in a selective purge |
| purge_busy | output | 1 | Purge sweep in progress |

## Verification
The bench installs two different tags in two ways of one index. Probing the first tag after the second install must miss, which a design comparing all ways would get wrong by reporting a hit. It issues an install and a lookup to the same index in one cycle. A design that forwards the write would hit there instead of missing on way 0. During a sweep it attempts both an install and a second purge start. If the install were not dropped, the predictor would move, and a restarted sweep would stretch `purge_busy` beyond 64 cycles. A selective purge must clear one ASID's entry and leave a neighbour with another ASID alone. After each purge, the way reported on a miss shows whether the purge wrongly reset the predictor.

// File: rtl/ltag_dir_pkg.sv
package ltag_dir_pkg;
  localparam int DEF_IDX_W  = 6;
  localparam int DEF_WAY_W  = 3;
  localparam int DEF_TAG_W  = 13;
  localparam int DEF_ASID_W = 8;

  typedef enum logic {
    PURGE_BY_SPACE   = 1'b0,
    PURGE_EVERYTHING = 1'b1
  } purge_mode_e;
endpackage

// File: rtl/ltag_setpred.sv
module ltag_setpred #(
  parameter int IDX_W = 6,
  parameter int WAY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAY_W-1:0] rd_way,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WAY_W-1:0] wr_way
);
  localparam int NIDX = 1 << IDX_W;

  logic [WAY_W-1:0] pred_q [NIDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NIDX; i++) pred_q[i] <= '0;
    end else if (wr_en) begin
      pred_q[wr_idx] <= wr_way;
    end
  end

  // small table kept in fabric; read combinationally to form the row address
  assign rd_way = pred_q[rd_idx];
endmodule

// File: rtl/ltag_tagram.sv
module ltag_tagram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 13
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // simple dual port, read-before-write, synchronous read
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/ltag_state.sv
module ltag_state #(
  parameter int IDX_W  = 6,
  parameter int WAY_W  = 3,
  parameter int ASID_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   lk_en,
  input  logic [IDX_W+WAY_W-1:0] lk_row,
  output logic                   lk_vld,
  output logic [ASID_W-1:0]      lk_asid,
  input  logic                   ins_en,
  input  logic [IDX_W+WAY_W-1:0] ins_row,
  input  logic [ASID_W-1:0]      ins_asid,
  input  logic                   prg_en,
  input  logic [IDX_W-1:0]       prg_idx,
  input  logic                   prg_all,
  input  logic [ASID_W-1:0]      prg_asid
);
  localparam int NIDX  = 1 << IDX_W;
  localparam int NWAYS = 1 << WAY_W;
  localparam int ROW_W = IDX_W + WAY_W;
  localparam int ROWS  = 1 << ROW_W;

  logic [NWAYS-1:0]  vld_q  [NIDX];
  logic [ASID_W-1:0] asid_q [ROWS];

  logic [IDX_W-1:0] ins_idx;
  logic [WAY_W-1:0] ins_way;
  logic [IDX_W-1:0] lk_idx;
  logic [WAY_W-1:0] lk_way;
  logic [NWAYS-1:0] kill;

  assign ins_idx = ins_row[ROW_W-1:WAY_W];
  assign ins_way = ins_row[WAY_W-1:0];
  assign lk_idx  = lk_row[ROW_W-1:WAY_W];
  assign lk_way  = lk_row[WAY_W-1:0];

  // per-way purge match at the swept index, all ways in one cycle
  for (genvar w = 0; w < NWAYS; w++) begin : g_kill
    assign kill[w] = prg_en &&
                     (prg_all || (asid_q[{prg_idx, WAY_W'(w)}] == prg_asid));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NIDX; i++) vld_q[i] <= '0;
    end else begin
      if (prg_en) vld_q[prg_idx] <= vld_q[prg_idx] & ~kill;
      if (ins_en) vld_q[ins_idx][ins_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) asid_q[ins_row] <= ins_asid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_vld  <= 1'b0;
      lk_asid <= '0;
    end else if (lk_en) begin
      lk_vld  <= vld_q[lk_idx][lk_way];
      lk_asid <= asid_q[lk_row];
    end
  end
endmodule

// File: rtl/ltag_purge_seq.sv
module ltag_purge_seq
  import ltag_dir_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  purge_mode_e       mode,
  input  logic [ASID_W-1:0] asid,
  output logic              busy,
  output logic [IDX_W-1:0]  cur_idx,
  output logic              cur_all,
  output logic [ASID_W-1:0] cur_asid
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      cur_idx  <= '0;
      cur_all  <= 1'b0;
      cur_asid <= '0;
    end else if (!busy) begin
      if (start) begin
        busy     <= 1'b1;
        cur_idx  <= '0;
        cur_all  <= (mode == PURGE_EVERYTHING);
        cur_asid <= asid;
      end
    end else begin
      if (cur_idx == LAST) busy <= 1'b0;
      cur_idx <= cur_idx + 1'b1;
    end
  end
endmodule

// File: rtl/ltag_dir.sv
module ltag_dir
  import ltag_dir_pkg::*;
#(
  parameter int IDX_W  = DEF_IDX_W,
  parameter int WAY_W  = DEF_WAY_W,
  parameter int TAG_W  = DEF_TAG_W,
  parameter int ASID_W = DEF_ASID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_idx,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [ASID_W-1:0] req_asid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [WAY_W-1:0]  rsp_set,
  output logic              miss_valid,
  input  logic              miss_ready,
  output logic [IDX_W-1:0]  miss_idx,
  output logic [TAG_W-1:0]  miss_tag,
  output logic [ASID_W-1:0] miss_asid,
  input  logic              inst_valid,
  input  logic [IDX_W-1:0]  inst_idx,
  input  logic [WAY_W-1:0]  inst_set,
  input  logic [TAG_W-1:0]  inst_tag,
  input  logic [ASID_W-1:0] inst_asid,
  input  logic              purge_start,
  input  logic              purge_all,
  input  logic [ASID_W-1:0] purge_asid,
  output logic              purge_busy
);
  localparam int ROW_W = IDX_W + WAY_W;

  logic              accept;
  logic              ins_ok;
  logic [WAY_W-1:0]  pred_way;
  logic [ROW_W-1:0]  rd_row;
  logic [ROW_W-1:0]  wr_row;
  logic [TAG_W-1:0]  e_tag;
  logic              e_vld;
  logic [ASID_W-1:0] e_asid;
  logic [IDX_W-1:0]  prg_idx;
  logic              prg_all;
  logic [ASID_W-1:0] prg_asid;
  purge_mode_e       pmode;

  logic              rsp_v_q;
  logic [IDX_W-1:0]  l_idx;
  logic [TAG_W-1:0]  l_tag;
  logic [ASID_W-1:0] l_asid;
  logic [WAY_W-1:0]  l_set;
  logic              miss_pend_q;
  logic              hit_now;

  assign pmode  = purge_mode_e'(purge_all);
  assign accept = req_valid && req_ready;
  assign ins_ok = inst_valid && !purge_busy;
  assign rd_row = {req_idx, pred_way};
  assign wr_row = {inst_idx, inst_set};

  ltag_setpred #(.IDX_W(IDX_W), .WAY_W(WAY_W)) u_pred (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (req_idx),
    .rd_way (pred_way),
    .wr_en  (ins_ok),
    .wr_idx (inst_idx),
    .wr_way (inst_set)
  );

  ltag_tagram #(.ADDR_W(ROW_W), .DATA_W(TAG_W)) u_tags (
    .clk     (clk),
    .rd_en   (accept),
    .rd_addr (rd_row),
    .rd_data (e_tag),
    .wr_en   (ins_ok),
    .wr_addr (wr_row),
    .wr_data (inst_tag)
  );

  ltag_state #(.IDX_W(IDX_W), .WAY_W(WAY_W), .ASID_W(ASID_W)) u_state (
    .clk      (clk),
    .rst      (rst),
    .lk_en    (accept),
    .lk_row   (rd_row),
    .lk_vld   (e_vld),
    .lk_asid  (e_asid),
    .ins_en   (ins_ok),
    .ins_row  (wr_row),
    .ins_asid (inst_asid),
    .prg_en   (purge_busy),
    .prg_idx  (prg_idx),
    .prg_all  (prg_all),
    .prg_asid (prg_asid)
  );

  ltag_purge_seq #(.IDX_W(IDX_W), .ASID_W(ASID_W)) u_purge (
    .clk      (clk),
    .rst      (rst),
    .start    (purge_start),
    .mode     (pmode),
    .asid     (purge_asid),
    .busy     (purge_busy),
    .cur_idx  (prg_idx),
    .cur_all  (prg_all),
    .cur_asid (prg_asid)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_v_q <= 1'b0;
      l_idx   <= '0;
      l_tag   <= '0;
      l_asid  <= '0;
      l_set   <= '0;
    end else begin
      rsp_v_q <= accept;
      if (accept) begin
        l_idx  <= req_idx;
        l_tag  <= req_tag;
        l_asid <= req_asid;
        l_set  <= pred_way;
      end
    end
  end

  assign hit_now = rsp_v_q && e_vld && (e_tag == l_tag) && (e_asid == l_asid);

  always_ff @(posedge clk) begin
    if (rst) miss_pend_q <= 1'b0;
    else     miss_pend_q <= miss_valid && !miss_ready;
  end

  assign rsp_valid  = rsp_v_q;
  assign rsp_hit    = hit_now;
  assign rsp_miss   = rsp_v_q && !hit_now;
  assign rsp_set    = l_set;
  assign miss_valid = (rsp_v_q && !hit_now) || miss_pend_q;
  assign miss_idx   = l_idx;
  assign miss_tag   = l_tag;
  assign miss_asid  = l_asid;
  assign req_ready  = !purge_busy && !miss_valid;
endmodule

// File: rtl/ltag_dir_chk.sv
module ltag_dir_chk #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic [TAG_W-1:0] miss_tag,
  input logic             purge_start,
  input logic             purge_busy
);
  localparam int SWEEP = 1 << IDX_W;

  logic [IDX_W:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst)             busy_cnt <= '0;
    else if (purge_busy) busy_cnt <= busy_cnt + 1'b1;
    else                 busy_cnt <= '0;
  end

  assert_rsp_follows_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  assert_no_spurious_rsp_R5: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  assert_hit_needs_rsp_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> rsp_valid);

  assert_miss_held_R6: assert property (@(posedge clk) disable iff (rst)
    (miss_valid && !miss_ready) |=> (miss_valid && $stable(miss_tag)));

  assert_miss_stalls_R6: assert property (@(posedge clk) disable iff (rst)
    miss_valid |-> !req_ready);

  assert_purge_stalls_R7: assert property (@(posedge clk) disable iff (rst)
    purge_busy |-> !req_ready);

  assert_purge_begins_R7: assert property (@(posedge clk) disable iff (rst)
    (purge_start && !purge_busy) |=> purge_busy);

  assert_purge_length_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(purge_busy) |-> (busy_cnt == (IDX_W+1)'(SWEEP)));
endmodule

bind ltag_dir ltag_dir_chk #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .miss_valid  (miss_valid),
  .miss_ready  (miss_ready),
  .miss_tag    (miss_tag),
  .purge_start (purge_start),
  .purge_busy  (purge_busy)
);

// File: tb/tb_ltag_dir.sv
`timescale 1ns/1ps
module tb_ltag_dir;
  localparam int IW = 6, WW = 3, TW = 13, AW = 8;

  logic clk = 0, rst = 1;
  logic req_valid = 0, miss_ready = 1, inst_valid = 0;
  logic purge_start = 0, purge_all = 0;
  logic [IW-1:0] req_idx = 0, inst_idx = 0;
  logic [TW-1:0] req_tag = 0, inst_tag = 0;
  logic [AW-1:0] req_asid = 0, inst_asid = 0, purge_asid = 0;
  logic [WW-1:0] inst_set = 0;
  logic req_ready, rsp_valid, rsp_hit, rsp_miss, miss_valid, purge_busy;
  logic [WW-1:0] rsp_set;
  logic [IW-1:0] miss_idx;
  logic [TW-1:0] miss_tag;
  logic [AW-1:0] miss_asid;

  int checks = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ltag_dir dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // lookup; samples the response one cycle after acceptance
  task automatic lookup(input int idx, tag, asid, exp_hit, exp_set, string req);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_idx = IW'(idx); req_tag = TW'(tag); req_asid = AW'(asid);
    @(posedge clk); #1;
    req_valid = 0;
    chk(req, "rsp_valid", rsp_valid, 1);
    chk(req, "rsp_hit", rsp_hit, exp_hit);
    chk(req, "rsp_set", rsp_set, exp_set);
  endtask

  task automatic install(input int idx, set, tag, asid);
    @(negedge clk);
    inst_valid = 1; inst_idx = IW'(idx); inst_set = WW'(set);
    inst_tag = TW'(tag); inst_asid = AW'(asid);
    @(posedge clk); #1;
    inst_valid = 0;
  endtask

  // runs a sweep; optionally injects an install and a second start mid-sweep
  task automatic purge(input bit all, input int asid, input bit inject, output int busy_n);
    @(negedge clk);
    purge_start = 1; purge_all = all; purge_asid = AW'(asid);
    @(posedge clk); #1;
    purge_start = 0;
    busy_n = 0;
    while (purge_busy) begin
      busy_n++;
      if (busy_n == 3) chk("R7", "req_ready during sweep", req_ready, 0);
      if (inject && busy_n == 5) begin
        inst_valid = 1; inst_idx = 60; inst_set = 5; inst_tag = 13'h30; inst_asid = 4;
        purge_start = 1; purge_all = 1;
      end
      @(posedge clk); #1;
      inst_valid = 0; purge_start = 0;
      if (busy_n > 200) break;
    end
  endtask

  task automatic t_reset();
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "purge_busy", purge_busy, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "miss_valid", miss_valid, 0);
    lookup(5, 13'h1AB, 3, 0, 0, "R1");
  endtask

  task automatic t_install_hit();
    install(10, 3, 13'h123, 7);
    lookup(10, 13'h123, 7, 1, 3, "R2");
    lookup(10, 13'h124, 7, 0, 3, "R3");
    lookup(10, 13'h123, 8, 0, 3, "R3");
  endtask

  task automatic t_one_way();
    install(10, 6, 13'h456, 7);
    lookup(10, 13'h123, 7, 0, 6, "R4");
    lookup(10, 13'h456, 7, 1, 6, "R4");
  endtask

  task automatic t_back_to_back();
    install(20, 1, 13'hA0, 2);
    install(21, 2, 13'hB0, 2);
    @(negedge clk);
    req_valid = 1; req_idx = 20; req_tag = 13'hA0; req_asid = 2;
    @(posedge clk); #1;
    req_idx = 21; req_tag = 13'hB0;
    chk("R5", "first hit", rsp_hit, 1);
    chk("R5", "first set", rsp_set, 1);
    @(posedge clk); #1;
    req_valid = 0;
    chk("R5", "second hit", rsp_hit, 1);
    chk("R5", "second set", rsp_set, 2);
    @(posedge clk); #1;
    chk("R5", "idle rsp_valid", rsp_valid, 0);
  endtask

  task automatic t_miss_handshake();
    miss_ready = 0;
    lookup(33, 13'h77, 3, 0, 0, "R6");
    chk("R6", "miss_valid", miss_valid, 1);
    repeat (3) @(posedge clk);
    #1;
    chk("R6", "miss_valid held", miss_valid, 1);
    chk("R6", "miss_idx", miss_idx, 33);
    chk("R6", "miss_tag", miss_tag, 'h77);
    chk("R6", "miss_asid", miss_asid, 3);
    chk("R6", "req_ready stalled", req_ready, 0);
    @(negedge clk); miss_ready = 1;
    @(posedge clk); #1;
    chk("R6", "miss_valid after accept", miss_valid, 0);
    chk("R6", "req_ready after accept", req_ready, 1);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    inst_valid = 1; inst_idx = 40; inst_set = 4; inst_tag = 13'h10; inst_asid = 1;
    req_valid = 1; req_idx = 40; req_tag = 13'h10; req_asid = 1;
    @(posedge clk); #1;
    inst_valid = 0; req_valid = 0;
    chk("R11", "hit with concurrent install", rsp_hit, 0);
    chk("R11", "set with concurrent install", rsp_set, 0);
    lookup(40, 13'h10, 1, 1, 4, "R11");
  endtask

  task automatic t_purge_space();
    int n;
    install(50, 0, 13'h20, 2);
    install(51, 1, 13'h21, 9);
    purge(0, 2, 1, n);
    chk("R9", "sweep length with restart", n, 64);
    lookup(50, 13'h20, 2, 0, 0, "R8");
    lookup(51, 13'h21, 9, 1, 1, "R8");
    lookup(60, 13'h30, 4, 0, 0, "R9");
  endtask

  task automatic t_purge_all();
    int n;
    purge(1, 0, 0, n);
    chk("R7", "sweep length", n, 64);
    lookup(51, 13'h21, 9, 0, 1, "R10");
    lookup(10, 13'h456, 7, 0, 6, "R10");
    lookup(20, 13'hA0, 2, 0, 1, "R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(posedge clk); #1;
    t_reset();
    t_install_hit();
    t_one_way();
    t_back_to_back();
    t_miss_handshake();
    t_same_cycle();
    t_purge_space();
    t_purge_all();
    repeat (2) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule